// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Controller

This block chooses the clock that the processor core runs on after a power-on reset or a wake-up from sleep. In crystal modes an external resonator needs time to settle. A start-up timer therefore counts 1024 rising edges of the external clock before that clock is trusted. In two-speed mode the core does not wait during this count. It runs from the internal clock, and once the count finishes the output clock is switched over to the external source without a glitch. A status flag then reports that the external source is in use. Without two-speed mode the core is held until the count completes.

The controller has two clock domains. A sequencer in the internal clock domain decides what the core may do and which source it wants. The edge counter runs in the external clock domain. A cross-coupled selector gates each source on its own falling edge, so the output never gets a short pulse. A sleep request stops the core and abandons any count in progress. A wake event clears the counter and the flag, then starts the sequence again.

Top module: `osc_startup_ctrl`

## Requirements
- R1: After reset in two-speed mode (switch-over enable 1, clock select 0, crystal mode code 0, 1 or 2), the flag is 0 and the core-run enable is 1. While the count runs, the output clock has exactly the edges of the internal clock.
- R2: The flag stays 0 until 1024 external rising edges have been counted. After that it rises, and the output clock carries the edges of the external clock.
- R3: The output clock never has a high or low phase shorter than the shorter half-period of the two sources. The internal and external gates are never open together.
- R4: In a crystal mode with switch-over disabled and clock select 0, the core-run enable stays 0 until the count completes. From then on it is 1 and the flag is set.
- R5: In external-clock or RC modes (codes 3, 4, 5) with clock select 0, there is no start-up delay. The core runs from reset, the output moves to the external clock within a few cycles, and the flag is set.
- R6: With clock select 1, or in the internal modes (codes 6, 7), the output clock stays on the internal source, the core runs, and the flag stays 0 however long the external clock runs.
- R7: A sleep request clears the core-run enable at the next internal rising edge. It abandons any count in progress, so the flag remains 0.
- R8: In crystal modes a wake event clears the flag within one internal clock cycle. It also restarts the count from zero, and in two-speed mode it returns the output to the internal clock.
- R9: The start-up counter never goes past 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| osc_mode | input | 3 | Oscillator mode: 0/1/2 crystal low/medium/high gain, 3 external clock, 4/5 RC, 6/7 internal |
| switch_en | input | 1 | Enables two-speed start-up |
| clk_sel_int | input | 1 | Software select: 1 forces the internal clock |
| wake | input | 1 | Wake event pulse, sampled on int_clk rising edge |
| sleep_req | input | 1 | Sleep request pulse, sampled on int_clk rising edge |
| sys_clk | output | 1 | Selected system clock |
| osc_stable | output | 1 | Set when the external source drives sys_clk after start-up |
| core_run | output | 1 | Core may advance |

## Verification
The core-run enable changes at the internal rising edge that samples sleep or wake, so it is checked 2.5 ns after the next rising edge. The flag changes on an internal falling edge, so after a wake it is checked at the following rising edge plus 2.5 ns. The end of the count arrives about 1331 internal cycles after reset. Flag and handover checks are therefore placed either well before that point (cycle 1200) or well after it (cycle 2200), which keeps them clear of synchronizer latency. Which source drives the output is judged by counting its edges over a 100-cycle window, allowing a difference of one, rather than by sampling near an edge.

// File: rtl/osu_pkg.sv
`timescale 1ns/1ps
package osu_pkg;

    typedef enum logic [2:0] {
        OSC_XT_LOW  = 3'd0,
        OSC_XT_MID  = 3'd1,
        OSC_XT_HIGH = 3'd2,
        OSC_EXT_CLK = 3'd3,
        OSC_RC_OUT  = 3'd4,
        OSC_RC_IO   = 3'd5,
        OSC_INT_OUT = 3'd6,
        OSC_INT_IO  = 3'd7
    } osc_mode_e;

    typedef enum logic [1:0] {
        SQ_RESTART = 2'd0,
        SQ_COUNT   = 2'd1,
        SQ_RUN     = 2'd2,
        SQ_SLEEP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic int_en;
        logic want;
        logic flag;
    } int_side_t;

    typedef struct packed {
        logic ext_en;
    } ext_side_t;

    // crystal resonator modes need the start-up count
    function automatic logic is_crystal(input logic [2:0] m);
        return m <= OSC_XT_HIGH;
    endfunction

    // modes whose primary clock comes from outside
    function automatic logic is_external(input logic [2:0] m);
        return m <= OSC_RC_IO;
    endfunction

endpackage

// File: rtl/osu_sync.sv
`timescale 1ns/1ps
module osu_sync #(
    parameter int STAGES  = 2,
    parameter bit FALL    = 1'b0,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], d};

    generate
        if (FALL) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= sh_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= sh_d;
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/osu_ost_counter.sv
`timescale 1ns/1ps
module osu_ost_counter #(
    parameter int OST_COUNT   = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(OST_COUNT + 1)
) (
    input  logic             ext_clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    output logic             done,
    output logic             idle,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OST_COUNT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             idle;
    } ost_regs_t;

    ost_regs_t c_d, c_q;
    logic      en_s;

    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b0)) u_en_sync (
        .clk(ext_clk), .rst_n(rst_n), .d(cnt_en), .q(en_s)
    );

    always_comb begin
        c_d = c_q;
        if (!en_s) begin
            c_d.cnt  = '0;
            c_d.done = 1'b0;
            c_d.idle = 1'b1;
        end else begin
            c_d.idle = 1'b0;
            if (c_q.cnt != LIMIT) c_d.cnt = c_q.cnt + 1'b1;
            c_d.done = (c_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge ext_clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt  <= '0;
            c_q.done <= 1'b0;
            c_q.idle <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign done = c_q.done;
    assign idle = c_q.idle;
    assign cnt  = c_q.cnt;
endmodule

// File: rtl/osu_seq.sv
`timescale 1ns/1ps
module osu_seq
    import osu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake,
    input  logic       sleep_req,
    input  logic [2:0] osc_mode,
    input  logic       switch_en,
    input  logic       sel_int,
    input  logic       done_s,
    input  logic       idle_s,
    output logic       cnt_en,
    output logic       want_ext,
    output logic       ready_ext,
    output logic       core_run
);
    seq_regs_t r_d, r_q;
    logic xtal, ext_src, two_speed, held;

    always_comb begin
        xtal      = is_crystal(osc_mode);
        ext_src   = !sel_int && is_external(osc_mode);
        two_speed = switch_en && !sel_int && xtal;
        held      = ext_src && xtal && !two_speed;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SQ_RESTART: begin
                // wait until the counter domain reports it is cleared
                if (sleep_req)              r_d.state = SQ_SLEEP;
                else if (idle_s && !done_s) r_d.state = SQ_COUNT;
            end
            SQ_COUNT: begin
                if (sleep_req)   r_d.state = SQ_SLEEP;
                else if (done_s) r_d.state = SQ_RUN;
            end
            SQ_RUN: begin
                if (sleep_req) r_d.state = SQ_SLEEP;
            end
            SQ_SLEEP: ;
            default: r_d.state = SQ_RESTART;
        endcase
        if (wake) r_d.state = SQ_RESTART;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.state <= SQ_RESTART;
        else        r_q <= r_d;
    end

    always_comb begin
        cnt_en    = (r_q.state == SQ_COUNT) || (r_q.state == SQ_RUN);
        ready_ext = ext_src && (xtal ? (r_q.state == SQ_RUN) : (r_q.state != SQ_SLEEP));
        want_ext  = ext_src && (r_q.state != SQ_SLEEP) && (ready_ext || !two_speed);
        core_run  = (r_q.state != SQ_SLEEP) && (!held || (r_q.state == SQ_RUN));
    end
endmodule

// File: rtl/osu_clk_mux.sv
`timescale 1ns/1ps
module osu_clk_mux
    import osu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic int_clk,
    input  logic ext_clk,
    input  logic rst_n,
    input  logic want_ext,
    input  logic ready_ext,
    output logic sys_clk,
    output logic int_en,
    output logic ext_en,
    output logic flag
);
    int_side_t i_d, i_q;
    ext_side_t e_d, e_q;
    logic ext_en_s, want_s, int_en_s;

    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b0)) u_ext_en_sync (
        .clk(int_clk), .rst_n(rst_n), .d(e_q.ext_en), .q(ext_en_s)
    );
    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b0)) u_want_sync (
        .clk(ext_clk), .rst_n(rst_n), .d(i_q.want), .q(want_s)
    );
    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_int_en_sync (
        .clk(ext_clk), .rst_n(rst_n), .d(i_q.int_en), .q(int_en_s)
    );

    // internal side: gate opens only once the external gate is seen shut
    always_comb begin
        i_d        = i_q;
        i_d.want   = want_ext;
        i_d.int_en = !want_ext && !ext_en_s;
        i_d.flag   = ready_ext && (i_q.flag || !i_d.int_en);
    end

    always_ff @(negedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q.int_en <= 1'b1;
            i_q.want   <= 1'b0;
            i_q.flag   <= 1'b0;
        end else begin
            i_q <= i_d;
        end
    end

    // external side: opens only once the internal gate is seen shut
    always_comb begin
        e_d        = e_q;
        e_d.ext_en = want_s && !int_en_s;
    end

    always_ff @(negedge ext_clk or negedge rst_n) begin
        if (!rst_n) e_q.ext_en <= 1'b0;
        else        e_q <= e_d;
    end

    assign sys_clk = (int_clk & i_q.int_en) | (ext_clk & e_q.ext_en);
    assign int_en  = i_q.int_en;
    assign ext_en  = e_q.ext_en;
    assign flag    = i_q.flag;
endmodule

// File: rtl/osc_startup_ctrl.sv
`timescale 1ns/1ps
module osc_startup_ctrl
    import osu_pkg::*;
#(
    parameter int OST_COUNT   = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       int_clk,
    input  logic       ext_clk,
    input  logic       rst_n,
    input  logic [2:0] osc_mode,
    input  logic       switch_en,
    input  logic       clk_sel_int,
    input  logic       wake,
    input  logic       sleep_req,
    output logic       sys_clk,
    output logic       osc_stable,
    output logic       core_run
);
    localparam int CNT_W = $clog2(OST_COUNT + 1);

    logic             cnt_en_w, done_w, idle_w, done_s, idle_s;
    logic             want_w, ready_w, int_en_w, ext_en_w;
    logic [CNT_W-1:0] ost_cnt_w;

    osu_ost_counter #(.OST_COUNT(OST_COUNT), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_cnt (
        .ext_clk(ext_clk), .rst_n(rst_n), .cnt_en(cnt_en_w),
        .done(done_w), .idle(idle_w), .cnt(ost_cnt_w)
    );

    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b0)) u_done_sync (
        .clk(int_clk), .rst_n(rst_n), .d(done_w), .q(done_s)
    );
    osu_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b1)) u_idle_sync (
        .clk(int_clk), .rst_n(rst_n), .d(idle_w), .q(idle_s)
    );

    osu_seq u_seq (
        .clk(int_clk), .rst_n(rst_n), .wake(wake), .sleep_req(sleep_req),
        .osc_mode(osc_mode), .switch_en(switch_en), .sel_int(clk_sel_int),
        .done_s(done_s), .idle_s(idle_s), .cnt_en(cnt_en_w),
        .want_ext(want_w), .ready_ext(ready_w), .core_run(core_run)
    );

    osu_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
        .want_ext(want_w), .ready_ext(ready_w), .sys_clk(sys_clk),
        .int_en(int_en_w), .ext_en(ext_en_w), .flag(osc_stable)
    );
endmodule

// File: rtl/osc_startup_chk.sv
`timescale 1ns/1ps
module osc_startup_chk #(
    parameter int CW        = 11,
    parameter int OST_COUNT = 1024
) (
    input logic          int_clk,
    input logic          ext_clk,
    input logic          rst_n,
    input logic          wake,
    input logic          sleep_req,
    input logic [2:0]    osc_mode,
    input logic          switch_en,
    input logic          clk_sel_int,
    input logic          osc_stable,
    input logic          core_run,
    input logic          int_en,
    input logic          ext_en,
    input logic [CW-1:0] ost_cnt
);
    logic xtal_sel, held_mode;
    assign xtal_sel  = (osc_mode <= 3'd2) && !clk_sel_int;
    assign held_mode = xtal_sel && !switch_en;

    p_gates_exclusive_r3: assert property (@(posedge int_clk) disable iff (!rst_n)
        !(int_en && ext_en));

    p_flag_only_external_r2: assert property (@(posedge int_clk) disable iff (!rst_n)
        osc_stable |-> !int_en);

    p_held_until_count_r4: assert property (@(posedge int_clk) disable iff (!rst_n)
        (held_mode && core_run) |-> osc_stable);

    p_internal_select_r6: assert property (@(posedge int_clk) disable iff (!rst_n)
        clk_sel_int |-> (!ext_en && !osc_stable));

    p_sleep_stops_core_r7: assert property (@(posedge int_clk) disable iff (!rst_n)
        (sleep_req && !wake) |=> !core_run);

    p_wake_clears_flag_r8: assert property (@(posedge int_clk) disable iff (!rst_n)
        (wake && xtal_sel) |=> !osc_stable);

    p_count_bounded_r9: assert property (@(posedge ext_clk) disable iff (!rst_n)
        ost_cnt <= CW'(OST_COUNT));
endmodule

bind osc_startup_ctrl osc_startup_chk #(.CW(CNT_W), .OST_COUNT(OST_COUNT)) u_chk (
    .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n), .wake(wake),
    .sleep_req(sleep_req), .osc_mode(osc_mode), .switch_en(switch_en),
    .clk_sel_int(clk_sel_int), .osc_stable(osc_stable), .core_run(core_run),
    .int_en(int_en_w), .ext_en(ext_en_w), .ost_cnt(ost_cnt_w)
);

// File: tb/osc_startup_ctrl_test.sv
`timescale 1ns/1ps
module osc_startup_ctrl_test;
    logic       int_clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0;
    logic [2:0] osc_mode = 3'd1;
    logic       switch_en = 1'b1, clk_sel_int = 1'b0, wake = 1'b0, sleep_req = 1'b0;
    logic       sys_clk, osc_stable, core_run;

    int  vectors = 0, miscompares = 0;
    int  n_sys = 0, n_int = 0, n_ext = 0, glitches = 0;
    bit  mon_en = 1'b0;
    real last_t = 0.0;

    always #5   int_clk = ~int_clk;   // 100 MHz internal
    always #6.5 ext_clk = ~ext_clk;   // unrelated external

    osc_startup_ctrl uut (
        .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n), .osc_mode(osc_mode),
        .switch_en(switch_en), .clk_sel_int(clk_sel_int), .wake(wake),
        .sleep_req(sleep_req), .sys_clk(sys_clk), .osc_stable(osc_stable),
        .core_run(core_run)
    );

    always @(posedge sys_clk) n_sys++;
    always @(posedge int_clk) n_int++;
    always @(posedge ext_clk) n_ext++;

    // R3: shortest legal phase is the internal half-period, 5 ns
    always @(sys_clk) begin
        if (mon_en && (($realtime - last_t) < 4.99)) glitches++;
        last_t = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge int_clk);
        #2.5;
    endtask

    task automatic start(input logic [2:0] m, input logic sw, input logic sel);
        @(negedge int_clk);
        mon_en = 1'b0;
        rst_n = 1'b0; wake = 1'b0; sleep_req = 1'b0;
        osc_mode = m; switch_en = sw; clk_sel_int = sel;
        repeat (5) @(negedge int_clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    // 1: output follows internal, 2: follows external
    task automatic source_is(input int which, input string req, input string what);
        int s0, i0, e0, ds, di, de;
        s0 = n_sys; i0 = n_int; e0 = n_ext;
        repeat (100) @(posedge int_clk);
        ds = n_sys - s0; di = n_int - i0; de = n_ext - e0;
        if (which == 1) chk((ds - di) <= 1 && (di - ds) <= 1, req, what, ds, di);
        else            chk((ds - de) <= 1 && (de - ds) <= 1, req, what, ds, de);
    endtask

    task automatic pulse_sleep();
        @(negedge int_clk); sleep_req = 1'b1;
        @(negedge int_clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge int_clk); wake = 1'b1;
        @(negedge int_clk); wake = 1'b0;
    endtask

    task automatic t_two_speed();
        start(3'd1, 1'b1, 1'b0);
        step(10);
        chk(osc_stable == 1'b0, "R1", "flag after reset", osc_stable, 0);
        chk(core_run == 1'b1, "R1", "core runs during count", core_run, 1);
        source_is(1, "R1", "sys edges vs internal during count");
        step(1090);
        chk(osc_stable == 1'b0, "R2", "flag before 1024 ext edges", osc_stable, 0);
        step(1000);
        chk(osc_stable == 1'b1, "R2", "flag after count", osc_stable, 1);
        chk(core_run == 1'b1, "R1", "core still running", core_run, 1);
        source_is(2, "R2", "sys edges vs external after handover");
    endtask

    task automatic t_held();
        start(3'd2, 1'b0, 1'b0);
        step(300);
        chk(core_run == 1'b0, "R4", "core held during count", core_run, 0);
        chk(osc_stable == 1'b0, "R4", "flag during count", osc_stable, 0);
        step(1900);
        chk(core_run == 1'b1, "R4", "core released", core_run, 1);
        chk(osc_stable == 1'b1, "R4", "flag after count", osc_stable, 1);
    endtask

    task automatic t_ext_clock();
        start(3'd3, 1'b1, 1'b0);
        step(50);
        chk(core_run == 1'b1, "R5", "core runs at once", core_run, 1);
        chk(osc_stable == 1'b1, "R5", "flag with no delay", osc_stable, 1);
        source_is(2, "R5", "sys edges vs external");
    endtask

    task automatic t_internal();
        start(3'd0, 1'b1, 1'b1);
        step(2200);
        chk(osc_stable == 1'b0, "R6", "flag with select internal", osc_stable, 0);
        chk(core_run == 1'b1, "R6", "core runs", core_run, 1);
        source_is(1, "R6", "sys edges vs internal, select");
        start(3'd6, 1'b1, 1'b0);
        step(2200);
        chk(osc_stable == 1'b0, "R6", "flag in internal mode", osc_stable, 0);
        source_is(1, "R6", "sys edges vs internal, mode 6");
    endtask

    task automatic t_sleep_wake();
        start(3'd0, 1'b1, 1'b0);
        step(600);
        pulse_sleep();
        step(1);
        chk(core_run == 1'b0, "R7", "core stops on sleep", core_run, 0);
        step(2000);
        chk(osc_stable == 1'b0, "R7", "count abandoned, flag clear", osc_stable, 0);
        source_is(1, "R7", "sys edges vs internal while asleep");
        pulse_wake();
        step(1);
        chk(core_run == 1'b1, "R8", "core runs after wake", core_run, 1);
        step(1000);
        chk(osc_stable == 1'b0, "R8", "count restarted from zero", osc_stable, 0);
        step(1400);
        chk(osc_stable == 1'b1, "R8", "flag after restarted count", osc_stable, 1);
        pulse_wake();
        step(1);
        chk(osc_stable == 1'b0, "R8", "wake clears flag in one cycle", osc_stable, 0);
        step(20);
        source_is(1, "R8", "sys edges vs internal after wake");
    endtask

    initial begin
        t_two_speed();
        t_held();
        t_ext_clock();
        t_internal();
        t_sleep_wake();
        chk(glitches == 0, "R3", "short sys_clk phases", glitches, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge int_clk);
        miscompares++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule